// File: doc/BRIEF.md
# Ping-Pong Memory-to-Peripheral DMA Channel

This block is one DMA channel that streams bytes from memory into a single peripheral. It uses two buffer slots held in registers rather than descriptors fetched from memory. Each slot holds a start address and a byte count. While one slot drains, software refills the other. When the running slot empties and the other slot holds work, the channel switches to it without a gap and raises a next-buffer event. When no slot holds work, the channel parks in a stall state and raises a stall event.

Software reaches the channel through a 32-bit register port with a combinational read path. The channel reads memory one byte per single-beat request and hands each byte to the peripheral with a one-cycle acknowledge, but only while the peripheral requests data. A four-value state code in a status register shows whether the channel is idle, stalled, running one slot, or running with the other slot queued. A single interrupt line combines the event flags with their enable bits.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset every register reads zero, the state code is idle (0), `irq` is low and neither `mem_req` nor `per_ack` is asserted.
- R2: The control word at 0x00 keeps only bit 0 (stall interrupt enable), bit 1 (next-buffer interrupt enable), bit 3 (error interrupt enable), bit 4 (channel enable) and bit 6 (a stored spare enable). The allocation word at 0x08 keeps its low 4 bits and drives them on `per_sel`. The count words (slot 0 at 0x20, slot 1 at 0x30) keep 16 bits. The address words (slot 0 at 0x24, slot 1 at 0x34) keep 32 bits.
- R3: A write to a slot's address word marks that slot loaded. With the channel enabled, a loaded slot delivers exactly its count of bytes to the peripheral, read from consecutive addresses upward from its start address, in address order.
- R4: When the running slot empties while the channel is enabled and the other slot is loaded, the channel moves to the other slot and sets the next-buffer flag (bit 1 of the event word at 0x04). The state code in status bits [5:4] reads 3 while the other slot is queued and 2 while only the running slot holds work.
- R5: When the running slot empties while the channel is enabled and the other slot is not loaded, the channel sets the stall flag (bit 0 of the event word) and the state code reads 1.
- R6: An enabled channel with no loaded slot reports state 1. A disabled channel that is not draining reports state 0, even if slots are loaded.
- R7: If the enable bit is cleared while a slot runs, that slot completes. The queued slot is not started and no event flag is set. The state code then reads 1 for exactly one cycle before it returns to 0.
- R8: `irq` is high exactly when an event flag is set and its enable bit is set (stall with bit 0, next-buffer with bit 1, error with bit 3).
- R9: An error response on a memory read sets the error flag (bit 3 of the event word). The byte is still delivered and the slot carries on.
- R10: Any write to the event word clears the error flag. A 1 written in bit 0 or bit 1 clears the stall or next-buffer flag.
- R11: A slot loaded with a count of zero completes without any memory read and then follows R4 or R5.
- R12: No memory read is started while `per_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Memory byte address |
| mem_ack | input | 1 | Memory read acknowledge |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| per_sel | output | 4 | Selected peripheral port |
| per_req | input | 1 | Peripheral asks for a byte |
| per_ack | output | 1 | One-cycle strobe: `per_data` holds a byte |
| per_data | output | 8 | Byte delivered to the peripheral |

## Verification
Every cycle, the assertions check three things: a memory request holds until it is acknowledged, each peripheral strobe lasts one cycle, and no request starts without a peripheral request. They also check that a byte completes only inside a running slot, that emptying a slot with the other one queued flips the active slot, and that a write-one acknowledge clears the next-buffer flag. Only the bench scenarios can show the rest: the byte order across a slot switch, the single stall cycle of a drain, the skipped zero-count slot, the transfer that continues past an error, and the combination of flags and enables on `irq`.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_STALL = 2'd1,
        CH_ON    = 2'd2,
        CH_NEXT  = 2'd3
    } ch_state_e;

    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_READ = 2'd1,
        MV_PUSH = 2'd2
    } mv_state_e;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_EVT   = 8'h04;
    localparam logic [7:0] OFS_ALLOC = 8'h08;
    localparam logic [7:0] OFS_STAT  = 8'h0C;
    localparam logic [7:0] OFS_CNT0  = 8'h20;
    localparam logic [7:0] OFS_BASE0 = 8'h24;
    localparam logic [7:0] OFS_CNT1  = 8'h30;
    localparam logic [7:0] OFS_BASE1 = 8'h34;

    localparam int CB_STALL_IE = 0;
    localparam int CB_NFB_IE   = 1;
    localparam int CB_ERR_IE   = 3;
    localparam int CB_EN       = 4;
    localparam int CB_SPARE    = 6;

    localparam logic [31:0] CTRL_KEEP = 32'h0000_005B;

    typedef struct packed {
        logic err;
        logic nfb;
        logic stall;
    } evt_t;

    function automatic logic [31:0] evt_word(evt_t e);
        return {28'd0, e.err, 1'b0, e.nfb, e.stall};
    endfunction

    function automatic logic [31:0] stat_word(ch_state_e s);
        return {26'd0, s, 4'd0};
    endfunction

endpackage

// File: rtl/pp_dma_mover.sv
module pp_dma_mover
    import ppdma_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              have_bytes,
    input  logic              per_req,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              per_ack,
    output logic [DATA_W-1:0] per_data,
    output logic              byte_done,
    output logic              idle,
    output logic              err_evt
);

    mv_state_e          st;
    logic [DATA_W-1:0]  hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= MV_IDLE;
            hold_q <= '0;
        end else begin
            unique case (st)
                MV_IDLE: if (have_bytes && per_req) st <= MV_READ;
                MV_READ: if (mem_ack) begin
                    hold_q <= mem_rdata;
                    st     <= MV_PUSH;
                end
                MV_PUSH: st <= MV_IDLE;
                default: st <= MV_IDLE;
            endcase
        end
    end

    assign mem_req   = (st == MV_READ);
    assign per_ack   = (st == MV_PUSH);
    assign per_data  = hold_q;
    assign byte_done = per_ack;
    assign idle      = (st == MV_IDLE);
    assign err_evt   = mem_req && mem_ack && mem_err;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req);

    // R3
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        per_ack |=> !per_ack);

    // R12
    req_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(per_req));

endmodule

// File: rtl/pp_dma_seq.sv
module pp_dma_seq
    import ppdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic [1:0]             wr_cnt,
    input  logic [1:0]             wr_base,
    input  logic [31:0]            wdata,
    input  logic                   byte_done,
    input  logic                   mover_idle,
    output logic [1:0][CNT_W-1:0]  cnt_rb,
    output logic [1:0][ADDR_W-1:0] base_rb,
    output logic [ADDR_W-1:0]      cur_addr,
    output logic                   have_bytes,
    output ch_state_e              state,
    output logic                   nfb_evt,
    output logic                   stall_evt
);

    logic [1:0][CNT_W-1:0]  cnt_q;
    logic [1:0][ADDR_W-1:0] base_q;
    logic [1:0]             vld_q;
    logic                   cur_q;
    logic                   active_q;
    logic                   drain_q;
    logic [ADDR_W-1:0]      addr_q;
    logic [CNT_W-1:0]       rem_q;

    logic other;
    logic finish;
    logic advance;

    assign other   = ~cur_q;
    assign finish  = active_q && (rem_q == '0) && mover_idle;
    assign advance = finish && en && vld_q[other];

    assign nfb_evt    = advance;
    assign stall_evt  = finish && en && !vld_q[other];
    assign have_bytes = active_q && (rem_q != '0);
    assign cur_addr   = addr_q;
    assign cnt_rb     = cnt_q;
    assign base_rb    = base_q;

    always_comb begin
        if (active_q)
            state = vld_q[other] ? CH_NEXT : CH_ON;
        else if (en || drain_q)
            state = CH_STALL;
        else
            state = CH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            base_q   <= '0;
            vld_q    <= '0;
            cur_q    <= 1'b0;
            active_q <= 1'b0;
            drain_q  <= 1'b0;
            addr_q   <= '0;
            rem_q    <= '0;
        end else begin
            drain_q <= 1'b0;
            if (!active_q) begin
                if (en && vld_q[cur_q]) begin
                    active_q <= 1'b1;
                    addr_q   <= base_q[cur_q];
                    rem_q    <= cnt_q[cur_q];
                end else if (en && vld_q[other]) begin
                    active_q <= 1'b1;
                    cur_q    <= other;
                    addr_q   <= base_q[other];
                    rem_q    <= cnt_q[other];
                end
            end else if (byte_done) begin
                addr_q <= addr_q + 1'b1;
                rem_q  <= rem_q - 1'b1;
            end else if (finish) begin
                vld_q[cur_q] <= 1'b0;
                if (advance) begin
                    cur_q  <= other;
                    addr_q <= base_q[other];
                    rem_q  <= cnt_q[other];
                end else begin
                    active_q <= 1'b0;
                    drain_q  <= !en;
                end
            end
            for (int b = 0; b < 2; b++) begin
                if (wr_cnt[b])
                    cnt_q[b] <= wdata[CNT_W-1:0];
                if (wr_base[b]) begin
                    base_q[b] <= wdata[ADDR_W-1:0];
                    vld_q[b]  <= 1'b1;
                end
            end
        end
    end

    // R3
    byte_in_buf_chk: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> active_q);

    // R4
    buf_flip_chk: assert property (@(posedge clk) disable iff (rst)
        advance |=> (cur_q != $past(cur_q)));

endmodule

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
    import ppdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_we,
    input  logic [7:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  ch_state_e              state,
    input  logic [1:0][CNT_W-1:0]  cnt_rb,
    input  logic [1:0][ADDR_W-1:0] base_rb,
    input  evt_t                   evt_set,
    output logic                   en,
    output logic [SEL_W-1:0]       per_sel,
    output logic [1:0]             wr_cnt,
    output logic [1:0]             wr_base,
    output logic                   irq
);

    logic [31:0]      ctrl_q;
    logic [SEL_W-1:0] alloc_q;
    evt_t             flags_q;
    logic             evt_wr;

    assign evt_wr     = reg_we && (reg_addr == OFS_EVT);
    assign wr_cnt[0]  = reg_we && (reg_addr == OFS_CNT0);
    assign wr_cnt[1]  = reg_we && (reg_addr == OFS_CNT1);
    assign wr_base[0] = reg_we && (reg_addr == OFS_BASE0);
    assign wr_base[1] = reg_we && (reg_addr == OFS_BASE1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            alloc_q <= '0;
            flags_q <= '0;
        end else begin
            if (reg_we && (reg_addr == OFS_CTRL))
                ctrl_q <= reg_wdata & CTRL_KEEP;
            if (reg_we && (reg_addr == OFS_ALLOC))
                alloc_q <= reg_wdata[SEL_W-1:0];
            flags_q.stall <= evt_set.stall | (flags_q.stall & !(evt_wr && reg_wdata[0]));
            flags_q.nfb   <= evt_set.nfb   | (flags_q.nfb   & !(evt_wr && reg_wdata[1]));
            flags_q.err   <= evt_set.err   | (flags_q.err   & !evt_wr);
        end
    end

    assign en      = ctrl_q[CB_EN];
    assign per_sel = alloc_q;
    assign irq     = (flags_q.stall && ctrl_q[CB_STALL_IE])
                   | (flags_q.nfb   && ctrl_q[CB_NFB_IE])
                   | (flags_q.err   && ctrl_q[CB_ERR_IE]);

    always_comb begin
        unique case (reg_addr)
            OFS_CTRL:  reg_rdata = ctrl_q;
            OFS_EVT:   reg_rdata = evt_word(flags_q);
            OFS_ALLOC: reg_rdata = 32'(alloc_q);
            OFS_STAT:  reg_rdata = stat_word(state);
            OFS_CNT0:  reg_rdata = 32'(cnt_rb[0]);
            OFS_BASE0: reg_rdata = 32'(base_rb[0]);
            OFS_CNT1:  reg_rdata = 32'(cnt_rb[1]);
            OFS_BASE1: reg_rdata = 32'(base_rb[1]);
            default:   reg_rdata = '0;
        endcase
    end

    // R10
    nfb_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_wr && reg_wdata[1] && !evt_set.nfb) |=> !flags_q.nfb);

endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
    import ppdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic [SEL_W-1:0]  per_sel,
    input  logic              per_req,
    output logic              per_ack,
    output logic [DATA_W-1:0] per_data
);

    logic                   en;
    logic [1:0]             wr_cnt;
    logic [1:0]             wr_base;
    logic [1:0][CNT_W-1:0]  cnt_rb;
    logic [1:0][ADDR_W-1:0] base_rb;
    logic                   have_bytes;
    logic                   byte_done;
    logic                   mover_idle;
    ch_state_e              state;
    evt_t                   evt_set;

    pp_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .state(state), .cnt_rb(cnt_rb), .base_rb(base_rb), .evt_set(evt_set),
        .en(en), .per_sel(per_sel), .wr_cnt(wr_cnt), .wr_base(wr_base), .irq(irq)
    );

    pp_dma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .en(en),
        .wr_cnt(wr_cnt), .wr_base(wr_base), .wdata(reg_wdata),
        .byte_done(byte_done), .mover_idle(mover_idle),
        .cnt_rb(cnt_rb), .base_rb(base_rb), .cur_addr(mem_addr),
        .have_bytes(have_bytes), .state(state),
        .nfb_evt(evt_set.nfb), .stall_evt(evt_set.stall)
    );

    pp_dma_mover #(.DATA_W(DATA_W)) u_mover (
        .clk(clk), .rst(rst),
        .have_bytes(have_bytes), .per_req(per_req),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .per_ack(per_ack), .per_data(per_data),
        .byte_done(byte_done), .idle(mover_idle), .err_evt(evt_set.err)
    );

endmodule

// File: tb/pp_dma_chan_tb.sv
module pp_dma_chan_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata;
    logic        mem_err;
    logic [3:0]  per_sel;
    logic        per_req = 1'b0;
    logic        per_ack;
    logic [7:0]  per_data;

    int errors = 0;
    int checks = 0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [7:0]  got [0:31];
    int          n_got = 0;
    int          n_reads = 0;

    always #2 clk = ~clk;

    pp_dma_chan u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .per_sel(per_sel),
        .per_req(per_req), .per_ack(per_ack), .per_data(per_data)
    );

    // memory model: ack one cycle after request, data is address xor A5
    assign mem_rdata = mem_addr[7:0] ^ 8'hA5;
    assign mem_err   = mem_ack && (mem_addr == err_addr);
    always @(posedge clk) mem_ack <= mem_req && !mem_ack;

    always @(negedge clk) begin
        if (per_ack && n_got < 32) begin
            got[n_got] = per_data;
            n_got++;
        end
        if (mem_ack) n_reads++;
    end

    localparam logic [7:0]  VOFS [0:5] = '{8'h00, 8'h08, 8'h20, 8'h24, 8'h30, 8'h34};
    localparam logic [31:0] VWR  [0:5] = '{32'hFFFF_FFEF, 32'hFFFF_FFFA, 32'h1234_ABCD,
                                           32'hDEAD_BEEF, 32'hFFFF_0000, 32'h0000_0001};
    localparam logic [31:0] VEXP [0:5] = '{32'h0000_004B, 32'h0000_000A, 32'h0000_ABCD,
                                           32'hDEAD_BEEF, 32'h0000_0000, 32'h0000_0001};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] ofs, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ofs; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] ofs, output logic [31:0] d);
        reg_addr = ofs;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; per_req = 1'b0; err_addr = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        n_got = 0; n_reads = 0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int stall_n;
        bit saw_idle;

        do_reset();
        // R1 reset state
        for (int i = 0; i < 6; i++) begin
            rd(VOFS[i], v);
            chk(v == 32'h0, "R1 register after reset", v, 32'h0);
        end
        rd(8'h04, v); chk(v == 32'h0, "R1 event word after reset", v, 32'h0);
        rd(8'h0C, v); chk(v == 32'h0, "R1 state idle after reset", v, 32'h0);
        chk(!irq && !mem_req && !per_ack, "R1 outputs quiet after reset",
            {29'd0, irq, mem_req, per_ack}, 32'h0);

        // R2 register readback table
        for (int i = 0; i < 6; i++) begin
            wr(VOFS[i], VWR[i]);
            rd(VOFS[i], v);
            chk(v == VEXP[i], "R2 register readback", v, VEXP[i]);
        end
        chk(per_sel == 4'hA, "R2 per_sel follows allocation", 32'(per_sel), 32'hA);
        // R6 disabled with loaded slots stays idle
        idle_cycles(3);
        rd(8'h0C, v); chk(v == 32'h00, "R6 disabled channel idle", v, 32'h0);
        chk(n_reads == 0, "R6 no reads while disabled", n_reads, 0);

        // ping-pong run: slot0 3 bytes at 0x40, slot1 2 bytes at 0x80
        do_reset();
        per_req = 1'b1;
        wr(8'h20, 32'd3); wr(8'h24, 32'h40);
        wr(8'h30, 32'd2); wr(8'h34, 32'h80);
        wr(8'h00, 32'h13);
        @(negedge clk);
        rd(8'h0C, v); chk(v == 32'h30, "R4 state next while other slot queued", v, 32'h30);
        idle_cycles(60);
        chk(n_got == 5, "R3 byte count over two slots", n_got, 5);
        begin
            logic [7:0] exp_b [0:4] = '{8'h40 ^ 8'hA5, 8'h41 ^ 8'hA5, 8'h42 ^ 8'hA5,
                                         8'h80 ^ 8'hA5, 8'h81 ^ 8'hA5};
            for (int i = 0; i < 5; i++)
                chk(got[i] == exp_b[i], "R3 byte order and value", 32'(got[i]), 32'(exp_b[i]));
        end
        rd(8'h04, v); chk(v == 32'h3, "R4 R5 next-buffer and stall flags", v, 32'h3);
        rd(8'h0C, v); chk(v == 32'h10, "R5 state stall after both slots", v, 32'h10);
        chk(irq == 1'b1, "R8 irq with enabled flags", 32'(irq), 32'h1);
        wr(8'h00, 32'h10);
        chk(irq == 1'b0, "R8 irq masked by enables", 32'(irq), 32'h0);
        rd(8'h0C, v); chk(v == 32'h10, "R6 enabled without slots stalls", v, 32'h10);
        wr(8'h04, 32'h2);
        rd(8'h04, v); chk(v == 32'h1, "R10 write-one clears next-buffer", v, 32'h1);
        wr(8'h04, 32'h1);
        rd(8'h04, v); chk(v == 32'h0, "R10 write-one clears stall", v, 32'h0);
        wr(8'h00, 32'h00);
        rd(8'h0C, v); chk(v == 32'h00, "R6 disabled returns idle", v, 32'h0);

        // error response mid-slot
        do_reset();
        per_req = 1'b1;
        err_addr = 32'h11;
        wr(8'h20, 32'd3); wr(8'h24, 32'h10);
        wr(8'h00, 32'h18);
        idle_cycles(40);
        chk(n_got == 3, "R9 transfer continues after error", n_got, 3);
        chk(got[1] == (8'h11 ^ 8'hA5), "R9 errored byte delivered", 32'(got[1]), 32'(8'h11 ^ 8'hA5));
        chk(got[2] == (8'h12 ^ 8'hA5), "R9 byte after error", 32'(got[2]), 32'(8'h12 ^ 8'hA5));
        rd(8'h04, v); chk(v == 32'h9, "R9 error flag set", v, 32'h9);
        chk(irq == 1'b1, "R8 irq from error", 32'(irq), 32'h1);
        wr(8'h04, 32'h0);
        rd(8'h04, v); chk(v == 32'h1, "R10 any write clears error", v, 32'h1);
        chk(irq == 1'b0, "R8 irq drops after error clear", 32'(irq), 32'h0);

        // drain: disable mid-slot with other slot queued
        do_reset();
        wr(8'h20, 32'd4); wr(8'h24, 32'h20);
        wr(8'h30, 32'd2); wr(8'h34, 32'h30);
        wr(8'h00, 32'h13);
        idle_cycles(4);
        chk(n_reads == 0, "R12 no read without peripheral request", n_reads, 0);
        rd(8'h0C, v); chk(v == 32'h30, "R4 queued state while waiting", v, 32'h30);
        wr(8'h00, 32'h03);
        per_req = 1'b1;
        stall_n = 0; saw_idle = 1'b0;
        for (int i = 0; i < 80 && !saw_idle; i++) begin
            @(negedge clk);
            rd(8'h0C, v);
            if (v == 32'h10) stall_n++;
            if (v == 32'h00) saw_idle = 1'b1;
        end
        chk(saw_idle, "R7 drain ends idle", 32'(saw_idle), 32'h1);
        chk(stall_n == 1, "R7 one stall cycle in drain", stall_n, 1);
        chk(n_got == 4, "R7 only running slot drained", n_got, 4);
        chk(got[3] == (8'h23 ^ 8'hA5), "R7 last drained byte", 32'(got[3]), 32'(8'h23 ^ 8'hA5));
        rd(8'h04, v); chk(v == 32'h0, "R7 no flags on drain", v, 32'h0);

        // zero-count slot
        do_reset();
        per_req = 1'b1;
        wr(8'h20, 32'd0); wr(8'h24, 32'h50);
        wr(8'h30, 32'd1); wr(8'h34, 32'h60);
        wr(8'h00, 32'h13);
        idle_cycles(30);
        chk(n_reads == 1, "R11 zero-count slot makes no read", n_reads, 1);
        chk(n_got == 1 && got[0] == (8'h60 ^ 8'hA5), "R11 next slot delivered",
            32'(got[0]), 32'(8'h60 ^ 8'hA5));
        rd(8'h04, v); chk(v == 32'h3, "R11 flags after zero-count slot", v, 32'h3);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule